// File: doc/BRIEF.md
# Push-Pull PWM Controller with Soft Start and Shutdown

This block drives the two switches of a push-pull power stage from a digital duty command. An internal counter forms a sawtooth ramp whose length is set in clock cycles, and the final cycles of each ramp form a blanking interval. During blanking both outputs are held low, and the interval doubles as the oscillator clock pulse. A steering flip-flop changes state at the end of every blanking interval, so output A and output B take turns, one pulse per ramp. Each pulse starts when the ramp restarts. It ends when the ramp reaches the effective duty command. A pulse-terminating latch then keeps the output low until the next blanking interval.

The effective duty command is the smaller of the duty input and a soft-start level. The soft-start level climbs slowly from zero. A shutdown input cuts both outputs in the same cycle. A short shutdown only ends the present pulse. A long one drains the soft-start level, so the converter restarts gently. An undervoltage-lockout flag holds the outputs off and the soft-start level at zero. A sync input lets several controllers share one external period.

Top module: `ppwm_ctrl`

## Requirements
- R1: With Deff = max(dead_cfg, 1) and Peff = max(period_cfg, Deff + 2), the ramp repeats every Peff cycles and `osc_clk` is high for exactly Deff consecutive cycles at the end of each ramp.
- R2: `steer` is 0 after reset and flips each time a blanking interval ends. `out_a` may pulse only while `steer` is 0, and `out_b` only while it is 1, so each output pulses at most once every 2*Peff cycles. The two outputs are never high together.
- R3: An output is high from the first ramp cycle for min(duty_eff, Peff - Deff) cycles and is low whenever `osc_clk` is high. A duty_eff of zero gives no pulses.
- R4: Once a pulse has ended within a ramp, raising the duty command cannot start another pulse before the next blanking interval.
- R5: A high `shutdown` drives both outputs low in the same cycle. After release, the outputs stay low until the next blanking interval. A one-cycle shutdown leaves later pulses at full width.
- R6: The soft-start level is 0 after reset. It rises by 1 every 2^SS_STEP_LOG2 cycles while neither `shutdown` nor `uvlo` is high, and it saturates at 2^W - 1. duty_eff = min(duty_cmd, soft-start level).
- R7: While `shutdown` is held, the soft-start level falls by 1 per cycle down to 0. After a long shutdown, the pulses grow again from zero.
- R8: While `uvlo` is high, both outputs are low and the soft-start level is 0. After release, the soft-start level ramps up from zero.
- R9: A rising edge on `sync_in` sampled outside blanking starts the blanking interval on the next cycle. A rising edge sampled during blanking is ignored and does not change the blanking or ramp lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_cfg | input | W | Ramp length in cycles, including blanking |
| dead_cfg | input | W | Blanking length in cycles |
| duty_cmd | input | W | Duty command in ramp cycles |
| shutdown | input | 1 | Forces outputs off; discharges soft start while high |
| sync_in | input | 1 | External period restart; rising edge is active |
| uvlo | input | 1 | Undervoltage-lockout flag |
| out_a | output | 1 | Drive for switch A, high means on |
| out_b | output | 1 | Drive for switch B, high means on |
| osc_clk | output | 1 | Blanking / oscillator clock pulse |
| steer | output | 1 | Steering flip-flop state (0 selects A) |

## Verification
Shutdown and lockout gating act on the outputs without any register, so those checks sample at the falling edge in the same cycle the input was applied. A sync edge passes through one register before the ramp jumps into blanking, so the bench samples `osc_clk` at the second falling edge after it raises `sync_in`. Pulse widths and blanking lengths are counted over windows of 8*Peff cycles, and each window holds exactly four pulses per output whatever its phase. Every window starts only after the configuration has been held long enough for the ramp, the steering state and the soft-start level to settle.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;
   // Steering state: which output owns the current ramp
   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } steer_t;

   function automatic int unsigned pow2(input int unsigned e);
      return 32'd1 << e;
   endfunction
endpackage

// File: rtl/ppwm_osc.sv
// Sawtooth counter with programmable blanking tail and sync restart.
module ppwm_osc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] period_cfg,
   input  logic [W-1:0] dead_cfg,
   input  logic         sync_in,
   output logic [W:0]   ramp,
   output logic         blank,
   output logic         wrap
);
   localparam int CW = W + 1;

   logic [CW-1:0] dead_eff, per_min, per_eff, blank_start;
   logic          sync_q, sync_rise;

   always_comb begin
      dead_eff    = (dead_cfg == '0) ? CW'(1) : {1'b0, dead_cfg};
      per_min     = dead_eff + CW'(2);
      per_eff     = ({1'b0, period_cfg} < per_min) ? per_min : {1'b0, period_cfg};
      blank_start = per_eff - dead_eff;
      blank       = (ramp >= blank_start);
      wrap        = (ramp >= per_eff - CW'(1));
      sync_rise   = sync_in & ~sync_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ramp   <= '0;
         sync_q <= 1'b0;
      end else begin
         sync_q <= sync_in;
         if (wrap)
            ramp <= '0;
         else if (sync_rise && !blank)
            ramp <= blank_start;
         else
            ramp <= ramp + CW'(1);
      end
   end
endmodule

// File: rtl/ppwm_softstart.sv
// Soft-start level: slow climb, one-per-cycle drain on shutdown, cleared on lockout.
module ppwm_softstart #(
   parameter int W            = 8,
   parameter int SS_STEP_LOG2 = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shutdown,
   input  logic         uvlo,
   output logic [W-1:0] level
);
   localparam logic [W-1:0] LVL_MAX = '1;

   logic tick;

   generate
      if (SS_STEP_LOG2 == 0) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_prescaled
         logic [SS_STEP_LOG2-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre <= '0;
            else if (shutdown || uvlo)
               pre <= '0;
            else
               pre <= pre + 1'b1;
         end
         assign tick = &pre;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= '0;
      else if (uvlo)
         level <= '0;
      else if (shutdown)
         level <= (level != '0) ? level - 1'b1 : '0;
      else if (tick && level != LVL_MAX)
         level <= level + 1'b1;
   end
endmodule

// File: rtl/ppwm_outstage.sv
// Pulse-terminating latch, steering flip-flop and NOR output gating.
module ppwm_outstage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W:0]   ramp,
   input  logic         blank,
   input  logic         wrap,
   input  logic [W-1:0] duty_eff,
   input  logic         shutdown,
   input  logic         uvlo,
   output logic         out_a,
   output logic         out_b,
   output logic         steer
);
   import ppwm_pkg::*;

   steer_t phase;
   logic   term_latch, reached, gate;

   always_comb begin
      reached = (ramp >= {1'b0, duty_eff});
      gate    = blank | term_latch | reached | shutdown | uvlo;
      out_a   = ~(gate | (phase == PH_B));
      out_b   = ~(gate | (phase == PH_A));
      steer   = (phase == PH_B);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term_latch <= 1'b0;
         phase      <= PH_A;
      end else begin
         if (blank)
            term_latch <= 1'b0;
         else if (reached || shutdown || uvlo)
            term_latch <= 1'b1;
         if (wrap)
            phase <= (phase == PH_A) ? PH_B : PH_A;
      end
   end
endmodule

// File: rtl/ppwm_ctrl.sv
// Dual-output push-pull PWM controller, top level.
module ppwm_ctrl #(
   parameter int W            = 8,
   parameter int SS_STEP_LOG2 = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] period_cfg,
   input  logic [W-1:0] dead_cfg,
   input  logic [W-1:0] duty_cmd,
   input  logic         shutdown,
   input  logic         sync_in,
   input  logic         uvlo,
   output logic         out_a,
   output logic         out_b,
   output logic         osc_clk,
   output logic         steer
);
   generate
      if (W < 2 || W > 16) begin : g_bad_width
         $error("ppwm_ctrl: W must lie in 2..16");
      end
      if (SS_STEP_LOG2 < 0 || SS_STEP_LOG2 > 12) begin : g_bad_step
         $error("ppwm_ctrl: SS_STEP_LOG2 must lie in 0..12");
      end
   endgenerate

   logic [W:0]   ramp;
   logic         blank, wrap;
   logic [W-1:0] ss_level, duty_eff;

   ppwm_osc #(.W(W)) u_osc (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_cfg (period_cfg),
      .dead_cfg   (dead_cfg),
      .sync_in    (sync_in),
      .ramp       (ramp),
      .blank      (blank),
      .wrap       (wrap)
   );

   ppwm_softstart #(.W(W), .SS_STEP_LOG2(SS_STEP_LOG2)) u_ss (
      .clk      (clk),
      .rst_n    (rst_n),
      .shutdown (shutdown),
      .uvlo     (uvlo),
      .level    (ss_level)
   );

   assign duty_eff = (duty_cmd < ss_level) ? duty_cmd : ss_level;
   assign osc_clk  = blank;

   ppwm_outstage #(.W(W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .ramp     (ramp),
      .blank    (blank),
      .wrap     (wrap),
      .duty_eff (duty_eff),
      .shutdown (shutdown),
      .uvlo     (uvlo),
      .out_a    (out_a),
      .out_b    (out_b),
      .steer    (steer)
   );
endmodule

// File: rtl/ppwm_ctrl_chk.sv
module ppwm_ctrl_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] period_cfg,
   input logic [W-1:0] dead_cfg,
   input logic         shutdown,
   input logic         uvlo,
   input logic         out_a,
   input logic         out_b,
   input logic         osc_clk,
   input logic         steer,
   input logic [W-1:0] ss
);
   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_a && out_b));

   p_steer_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(osc_clk) && $stable(period_cfg) && $stable(dead_cfg)) |-> (steer != $past(steer)));

   p_blank_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      osc_clk |-> (!out_a && !out_b));

   p_shutdown_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!out_a && !out_b));

   p_ss_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!shutdown && !uvlo) |=> (ss == $past(ss) || ss == $past(ss) + 1'b1));

   p_ss_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown && !uvlo && ss != '0) |=> (ss == $past(ss) - 1'b1));

   p_uvlo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo |-> (!out_a && !out_b));

   p_uvlo_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo |=> (ss == '0));
endmodule

bind ppwm_ctrl ppwm_ctrl_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .period_cfg (period_cfg),
   .dead_cfg   (dead_cfg),
   .shutdown   (shutdown),
   .uvlo       (uvlo),
   .out_a      (out_a),
   .out_b      (out_b),
   .osc_clk    (osc_clk),
   .steer      (steer),
   .ss         (ss_level)
);

// File: tb/test_ppwm_ctrl.sv
`timescale 1ns/1ps
module test_ppwm_ctrl;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] period_cfg = 8'd20, dead_cfg = 8'd4, duty_cmd = 8'd200;
   logic         shutdown = 1'b0, sync_in = 1'b0, uvlo = 1'b0;
   logic         out_a, out_b, osc_clk, steer;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ppwm_ctrl #(.W(W), .SS_STEP_LOG2(2)) i_ppwm_ctrl (
      .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .dead_cfg(dead_cfg),
      .duty_cmd(duty_cmd), .shutdown(shutdown), .sync_in(sync_in), .uvlo(uvlo),
      .out_a(out_a), .out_b(out_b), .osc_clk(osc_clk), .steer(steer)
   );

   // period, deadtime, duty, expected Peff, expected Deff, expected pulse width
   localparam int NV = 7;
   localparam int VEC [NV][6] = '{
      '{20, 4,   6, 20, 4,  6},
      '{20, 4, 200, 20, 4, 16},
      '{10, 2,   0, 10, 2,  0},
      '{ 3, 4,   5,  6, 4,  2},
      '{50, 0,  30, 50, 1, 30},
      '{16, 8,   8, 16, 8,  8},
      '{16, 8, 255, 16, 8,  8}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive_cfg(input int p, input int d, input int u);
      @(posedge clk); #1;
      period_cfg = p[W-1:0];
      dead_cfg   = d[W-1:0];
      duty_cmd   = u[W-1:0];
   endtask

   task automatic measure(input int n, output int ha, output int hb, output int ho);
      ha = 0; hb = 0; ho = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ha += int'(out_a);
         hb += int'(out_b);
         ho += int'(osc_clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ha, hb, ho, hi, lo;
      bit prev;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // Reset state: R2 steering starts at 0, R6 soft start empty
      check(steer == 1'b0, "R2 reset steer", int'(steer), 0);
      check(!out_a && !out_b, "R6 reset outputs", int'(out_a) + int'(out_b), 0);

      // R6: soft start limits the first window
      measure(160, ha, hb, ho);
      check(ha + hb > 0 && ha + hb < 128, "R6 soft start ramp", ha + hb, 64);
      repeat (1000) @(posedge clk);

      // Table walk: R1 blanking length, R3 pulse widths, R2 alternation
      for (int v = 0; v < NV; v++) begin
         drive_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
         repeat (300) @(posedge clk);
         measure(8 * VEC[v][3], ha, hb, ho);
         check(ho == 8 * VEC[v][4], "R1 blanking cycles", ho, 8 * VEC[v][4]);
         check(ha == 4 * VEC[v][5], "R3 out_a width", ha, 4 * VEC[v][5]);
         check(hb == 4 * VEC[v][5], "R2 out_b width", hb, 4 * VEC[v][5]);
      end

      // R4: raising the command after a pulse ends gives no second pulse
      drive_cfg(20, 4, 4);
      repeat (100) @(posedge clk);
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (prev && !out_a) break;
         prev = out_a;
      end
      @(posedge clk); #1 duty_cmd = 8'd16;
      hi = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         hi += int'(out_a);
      end
      check(hi == 0, "R4 latch holds", hi, 0);

      // R5: short shutdown cuts the pulse now and keeps it cut
      drive_cfg(20, 4, 200);
      repeat (100) @(posedge clk);
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (!prev && out_a) break;
         prev = out_a;
      end
      @(posedge clk); #1 shutdown = 1'b1;
      @(negedge clk);
      check(!out_a && !out_b, "R5 same-cycle off", int'(out_a) + int'(out_b), 0);
      @(posedge clk); #1 shutdown = 1'b0;
      hi = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         hi += int'(out_a);
      end
      check(hi == 0, "R5 off after release", hi, 0);
      repeat (60) @(posedge clk);
      measure(160, ha, hb, ho);
      check(ha + hb == 128, "R5 soft start intact", ha + hb, 128);

      // R7: long shutdown drains soft start, restart is gradual
      @(posedge clk); #1 shutdown = 1'b1;
      measure(300, ha, hb, ho);
      check(ha + hb == 0, "R7 off while held", ha + hb, 0);
      @(posedge clk); #1 shutdown = 1'b0;
      measure(160, ha, hb, ho);
      check(ha + hb < 128, "R7 slow restart", ha + hb, 128);
      repeat (1100) @(posedge clk);
      measure(160, ha, hb, ho);
      check(ha + hb == 128, "R7 full again", ha + hb, 128);

      // R8: lockout holds outputs off and empties soft start
      @(posedge clk); #1 uvlo = 1'b1;
      measure(100, ha, hb, ho);
      check(ha + hb == 0, "R8 off in lockout", ha + hb, 0);
      @(posedge clk); #1 uvlo = 1'b0;
      measure(160, ha, hb, ho);
      check(ha + hb < 128, "R8 soft restart", ha + hb, 128);
      repeat (1100) @(posedge clk);

      // R9: sync outside blanking starts blanking next cycle
      drive_cfg(40, 4, 200);
      repeat (200) @(posedge clk);
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (prev && !osc_clk) break;
         prev = osc_clk;
      end
      @(posedge clk); #1 sync_in = 1'b1;
      @(negedge clk);
      @(posedge clk); #1 sync_in = 1'b0;
      @(negedge clk);
      check(osc_clk == 1'b1, "R9 sync starts blanking", int'(osc_clk), 1);
      hi = 1;
      forever begin
         @(negedge clk);
         if (!osc_clk) break;
         hi++;
      end
      check(hi == 4, "R9 blanking after sync", hi, 4);

      // R9: sync during blanking is ignored
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (!prev && osc_clk) break;
         prev = osc_clk;
      end
      hi = 1;
      @(posedge clk); #1 sync_in = 1'b1;
      @(negedge clk);
      hi += int'(osc_clk);
      @(posedge clk); #1 sync_in = 1'b0;
      forever begin
         @(negedge clk);
         if (!osc_clk) break;
         hi++;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (osc_clk) break;
         lo++;
      end
      check(hi == 4, "R9 ignored blanking length", hi, 4);
      check(lo == 36, "R9 ignored ramp length", lo, 36);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule